// File: doc/BRIEF.md
# Reversible Feistel Keystream Generator

This block stands in for a long random bit string. A 96-bit state is kept instead of the string. The block hands out the string one byte at a time and can walk along it forwards or backwards. The state is held as two 48-bit halves, `L` and `R`. A move command applies one Feistel round built on a fixed nonlinear mixing function, so the state advances one position. A flip command swaps the two halves. After a flip, the next moves undo the earlier ones, so the string is walked back the way it came.

The output byte combines the top byte of each half with XOR. Because of this, the byte at a given position is the same whichever way the walk is heading. The seed is written 48 bits at a time through a synchronous load. A full seed takes two load cycles, one for each half. The block is meant for arithmetic that reads a random operand sequentially and turns around once per result byte, where one extra cycle per turn is acceptable.

Top module: `feistel_keystream`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both halves are cleared to zero, and from the next cycle `key_byte` is 0.
- R2: With `load` high, `load_sel`=0 writes `seed` into `L` and `load_sel`=1 writes `seed` into `R`. The other half is kept.
- R3: With `move` high, `flip` low and `load` low, the state becomes (L, R) -> (R, L ^ F(R)). Here F(x) = rotl48(x + 48'h9E3779B97F4A, 7) ^ (x & rotl48(x, 12)), with the addition taken modulo 2^48.
- R4: With `flip` high and `load` low, the halves are swapped: (L, R) -> (R, L).
- R5: When `flip` and `move` are both high and `load` is low, only the swap of R4 takes place. The move is ignored.
- R6: When `load` is high, `move` and `flip` are ignored. Only the load of R2 takes place.
- R7: `key_byte` is combinational from the state and equals L[47:40] ^ R[47:40]. It shows the result of an update in the cycle after that update.
- R8: Starting from any state, k moves, one flip and then k further moves give back the starting state with its halves swapped. The bytes seen on the way back are the forward bytes in reverse order.
- R9: With `load`, `move` and `flip` all low, the state and `key_byte` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Write `seed` into one half |
| load_sel | input | 1 | Half to load: 0 = L, 1 = R |
| seed | input | 48 | Seed word |
| move | input | 1 | Advance one position in the current direction |
| flip | input | 1 | Reverse direction (swap halves) |
| key_byte | output | 8 | Byte at the current position |

## Verification
Long random runs mix moves, flips, loads and commands given together. A reference model follows every cycle, so errors in the round function, in which half a move feeds, or in the priority of commands all change the byte sequence. Directed walks of many moves, a flip and the same number of moves test reversibility. An F that is not undone by its own round, or a byte that is not symmetric, breaks the mirrored sequence. Separate cycles check reset, loading each half on its own, flip given together with move, and load given together with the other commands. These expose mistakes in half selection and priority that a random mix may hide.

// File: rtl/feistel_keystream.sv
module feistel_keystream #(
  parameter int HALF_W = 48,
  parameter int BYTE_W = 8,
  parameter logic [HALF_W-1:0] MIX_K = 48'h9E3779B97F4A,
  parameter int ROT_A = 7,
  parameter int ROT_B = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_sel,
  input  logic [HALF_W-1:0] seed,
  input  logic              move,
  input  logic              flip,
  output logic [BYTE_W-1:0] key_byte
);

  localparam int TOP = HALF_W - BYTE_W;

  logic [HALF_W-1:0] l_q, r_q;
  logic [HALF_W-1:0] mix_sum, mix_out;

  assign mix_sum = r_q + MIX_K;
  assign mix_out = ((mix_sum << ROT_A) | (mix_sum >> (HALF_W - ROT_A)))
                 ^ (r_q & ((r_q << ROT_B) | (r_q >> (HALF_W - ROT_B))));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_q <= '0;
      r_q <= '0;
    end else if (load) begin
      if (load_sel) r_q <= seed;
      else          l_q <= seed;
    end else if (flip) begin
      l_q <= r_q;
      r_q <= l_q;
    end else if (move) begin
      l_q <= r_q;
      r_q <= l_q ^ mix_out;
    end
  end

  assign key_byte = l_q[HALF_W-1:TOP] ^ r_q[HALF_W-1:TOP];

endmodule

module feistel_keystream_chk #(
  parameter int HALF_W = 48,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              load_sel,
  input logic [HALF_W-1:0] seed,
  input logic              move,
  input logic              flip,
  input logic [HALF_W-1:0] l_q,
  input logic [HALF_W-1:0] r_q,
  input logic [BYTE_W-1:0] key_byte
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (l_q == '0 && r_q == '0 && key_byte == '0));

  assert_load_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load && !load_sel |=> (l_q == $past(seed) && r_q == $past(r_q)));

  assert_load_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load && load_sel |=> (r_q == $past(seed) && l_q == $past(l_q)));

  assert_move_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    move && !flip && !load |=> l_q == $past(r_q));

  assert_flip_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flip && !load |=> (l_q == $past(r_q) && r_q == $past(l_q)));

  assert_flip_byte_same_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flip && !load |=> $stable(key_byte));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !move && !flip |=> ($stable(l_q) && $stable(r_q)));

endmodule

bind feistel_keystream feistel_keystream_chk #(.HALF_W(HALF_W), .BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .load(load), .load_sel(load_sel), .seed(seed),
  .move(move), .flip(flip), .l_q(l_q), .r_q(r_q), .key_byte(key_byte)
);

// File: tb/feistel_keystream_tb.sv
`timescale 1ns/1ps
module feistel_keystream_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic        load_sel = 1'b0;
  logic [47:0] seed = '0;
  logic        move = 1'b0;
  logic        flip = 1'b0;
  logic [7:0]  key_byte;

  int n_checks = 0;
  int n_fail = 0;
  logic [47:0] ml = '0, mr = '0;
  logic [7:0] trail [0:20];

  always #10 clk = ~clk;

  feistel_keystream dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_sel(load_sel), .seed(seed),
    .move(move), .flip(flip), .key_byte(key_byte)
  );

  function automatic logic [47:0] rotl(input logic [47:0] x, input int n);
    return (x << n) | (x >> (48 - n));
  endfunction

  function automatic logic [47:0] mixf(input logic [47:0] x);
    return rotl(x + 48'h9E3779B97F4A, 7) ^ (x & rotl(x, 12));
  endfunction

  function automatic logic [7:0] exp_byte();
    return ml[47:40] ^ mr[47:40];
  endfunction

  task automatic check(input logic [7:0] exp, input string req);
    n_checks++;
    if (key_byte !== exp) begin
      n_fail++;
      $display("FAIL %s: key_byte=%h expected=%h", req, key_byte, exp);
    end
  endtask

  task automatic cyc(input logic ld, input logic sel, input logic [47:0] sd,
                     input logic mv, input logic fl);
    logic [47:0] t;
    load = ld; load_sel = sel; seed = sd; move = mv; flip = fl;
    @(posedge clk);
    if (ld) begin
      if (sel) mr = sd; else ml = sd;
    end else if (fl) begin
      t = ml; ml = mr; mr = t;
    end else if (mv) begin
      t = ml; ml = mr; mr = t ^ mixf(mr);
    end
    @(negedge clk);
    load = 1'b0; move = 1'b0; flip = 1'b0;
  endtask

  task automatic seed_both(input logic [47:0] a, input logic [47:0] b);
    cyc(1, 0, a, 0, 0);
    check(exp_byte(), "R2");
    cyc(1, 1, b, 0, 0);
    check(exp_byte(), "R2");
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 0);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    rst_n = 1'b0;
    cyc(0, 0, 0, 1, 0);
    ml = '0; mr = '0;
    check(8'h00, "R1");
    rst_n = 1'b1;

    cyc(1, 0, 48'hA5_0000_0000_00, 0, 0);
    check(8'hA5, "R2 left only");
    cyc(1, 1, 48'h3C_1111_2222_33, 0, 0);
    check(8'hA5 ^ 8'h3C, "R2 right only");

    cyc(0, 0, 0, 1, 0);
    check(exp_byte(), "R3 single move");
    cyc(0, 0, 0, 0, 1);
    check(exp_byte(), "R4 flip");
    cyc(0, 0, 0, 1, 1);
    check(exp_byte(), "R5 flip beats move");
    cyc(1, 0, 48'h0F_0000_0000_00, 1, 1);
    check(exp_byte(), "R6 load beats move and flip");
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 0, 0, 0);
      check(exp_byte(), "R9 idle hold");
    end
    cyc(0, 0, 0, 1, 0);
    check(exp_byte(), "R7 byte after move");

    for (int rep = 0; rep < 4; rep++) begin
      seed_both({$urandom, $urandom} , {$urandom, $urandom});
      trail[0] = key_byte;
      for (int j = 1; j <= 20; j++) begin
        cyc(0, 0, 0, 1, 0);
        check(exp_byte(), "R3 walk");
        trail[j] = key_byte;
      end
      cyc(0, 0, 0, 0, 1);
      check(trail[20], "R8 byte after flip");
      for (int j = 1; j <= 20; j++) begin
        cyc(0, 0, 0, 1, 0);
        check(trail[20 - j], "R8 walk back");
      end
    end

    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom % 16);
      if (op < 9)       cyc(0, 0, 0, 1, 0);
      else if (op < 11) cyc(0, 0, 0, 0, 1);
      else if (op < 12) cyc(0, 0, 0, 1, 1);
      else if (op < 14) cyc(1, op[0], {$urandom, $urandom}, $urandom % 2 == 1, $urandom % 2 == 1);
      else              cyc(0, 0, 0, 0, 0);
      check(exp_byte(), "R3/R4/R5/R6/R7 random");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule